// File: doc/BRIEF.md
# Block Cipher Mode Chaining Unit

This unit sits between a stream of 128-bit data blocks and an external 128-bit block cipher engine. For each block it applies one of three modes of operation: the plain codebook mode (ECB), cipher block chaining (CBC) or counter mode (CTR), in either direction. It keeps a 128-bit chaining/counter register that software loads one 32-bit word at a time. The engine is reached through a one-cycle start strobe, operand and direction buses, and a done strobe that returns the result.

A control word, sampled when a block is accepted, selects the mode, the direction, the key-size code passed to the engine and, for CTR, how many low bits of the counter form the incrementing field. The unit handles one block at a time. `inReady` is high only while the unit is idle. The result appears on `outBlock` for exactly one cycle, marked by `outValid`.

Top module: `blkmode_chain`

## Requirements
- R1: After reset `inReady` is 1, `busy`, `outValid` and `engStart` are 0, and the chaining/counter register holds zero, so a CTR block issued before any IV load uses counter value 0.
- R2: Control bit 6 selects CTR and takes priority over control bit 5, which selects CBC. With both bits clear the mode is ECB, and the output is the engine result on the input block.
- R3: Control bit 2 sets the direction (1 encrypt, 0 decrypt) and drives `engEncrypt` in ECB and CBC. In CTR the engine always runs with `engEncrypt` = 1, and the output is the engine result XOR the input, so both directions give the same result.
- R4: Control bits 4:3 (key-size code: 1, 2 or 3 for 128-, 192- or 256-bit keys) are passed unchanged on `engKeySize` for the block.
- R5: In CBC encrypt the engine operand is input XOR chain, and the ciphertext becomes the new chain value. In CBC decrypt the output is engine result XOR chain, and the input ciphertext becomes the new chain value.
- R6: After each CTR block only the low field of the counter increments, modulo 2^w. The width w is 32, 64, 96 or 128 for control bits 8:7 = 0, 1, 2, 3, and the bits above the field are unchanged.
- R7: An IV write puts `ivWrData` into bits [32k+31:32k] of the chaining register, where k = `ivWrIdx`. The write is ignored while `busy` is 1. While idle, a write takes priority over block acceptance: `inReady` is 0 in that cycle, and the new value is used from the next block.
- R8: Each accepted block produces exactly one single-cycle `engStart`, in the cycle after acceptance, and exactly one single-cycle `outValid` after `engDone`.
- R9: `inReady` is 0 whenever `busy` is 1, so only one block is in flight at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| ctrlWord | input | 9 | Mode, direction, key-size code and counter width, sampled when a block is accepted |
| ivWrEn | input | 1 | IV word write strobe |
| ivWrIdx | input | 2 | Index of the IV word to write |
| ivWrData | input | 32 | IV word data |
| inValid | input | 1 | Input block offered |
| inBlock | input | 128 | Input block |
| inReady | output | 1 | Unit can accept a block this cycle |
| outValid | output | 1 | Result block valid (one cycle) |
| outBlock | output | 128 | Result block |
| busy | output | 1 | A block is in flight |
| engStart | output | 1 | Engine start strobe |
| engEncrypt | output | 1 | Engine direction: 1 forward, 0 inverse |
| engKeySize | output | 2 | Key-size code for the engine |
| engIn | output | 128 | Engine operand |
| engDone | input | 1 | Engine result ready |
| engOut | input | 128 | Engine result |

## Verification
The assertions check the handshake rules on every cycle: `engStart` and `outValid` are single-cycle pulses, an accepted block always leads to a start, `inReady` stays low while busy or while an IV write is offered, and the chaining register stays stable while a block is in flight until the engine answers. The data transforms can only be shown by the bench scenarios, which compare results against an independent model of each mode. These scenarios cover CBC chaining across several blocks and a round trip, CTR wrap inside each of the four field widths with the upper bits kept, an IV write issued while busy, the IV-versus-block priority case, and random mixes of modes and engine latencies.

// File: rtl/blkmode_pkg.sv
package blkmode_pkg;
  localparam int CTRL_W      = 9;
  localparam int CTL_DIR_BIT = 2;
  localparam int CTL_KSZ_LO  = 3;
  localparam int CTL_CBC_BIT = 5;
  localparam int CTL_CTR_BIT = 6;
  localparam int CTL_CW_LO   = 7;

  typedef enum logic [1:0] {MODE_ECB, MODE_CBC, MODE_CTR} modeT;

  typedef struct packed {
    modeT       mode;
    logic       enc;
    logic [1:0] keySz;
    logic [1:0] ctrSel;
  } cfgT;

  typedef struct packed {
    logic takeBlock;
    logic takeResult;
    logic ivWrite;
  } strobeT;

  function automatic cfgT decodeCtrl(input logic [CTRL_W-1:0] c);
    cfgT r;
    if (c[CTL_CTR_BIT])      r.mode = MODE_CTR;
    else if (c[CTL_CBC_BIT]) r.mode = MODE_CBC;
    else                     r.mode = MODE_ECB;
    r.enc    = c[CTL_DIR_BIT];
    r.keySz  = c[CTL_KSZ_LO +: 2];
    r.ctrSel = c[CTL_CW_LO +: 2];
    return r;
  endfunction
endpackage

// File: rtl/blkmode_ctrl.sv
module blkmode_ctrl
  import blkmode_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   ivWrEn,
  input  logic   engDone,
  output strobeT stb,
  output logic   inReady,
  output logic   busy,
  output logic   engStart,
  output logic   outValid
);
  typedef enum logic [1:0] {S_IDLE, S_LAUNCH, S_WAIT, S_EMIT} stateT;
  stateT state, stateNxt;

  always_comb begin
    inReady        = (state == S_IDLE) && !ivWrEn;
    stb.ivWrite    = (state == S_IDLE) && ivWrEn;
    stb.takeBlock  = inReady && inValid;
    stb.takeResult = (state == S_WAIT) && engDone;
    engStart       = (state == S_LAUNCH);
    outValid       = (state == S_EMIT);
    busy           = (state != S_IDLE);
  end

  always_comb begin
    stateNxt = state;
    unique case (state)
      S_IDLE:   if (stb.takeBlock) stateNxt = S_LAUNCH;
      S_LAUNCH: stateNxt = S_WAIT;
      S_WAIT:   if (engDone) stateNxt = S_EMIT;
      S_EMIT:   stateNxt = S_IDLE;
      default:  stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/blkmode_dp.sv
module blkmode_dp
  import blkmode_pkg::*;
#(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = BLK_W / WORD_W,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            stb,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic [BLK_W-1:0]  inBlock,
  input  logic [IDX_W-1:0]  ivWrIdx,
  input  logic [WORD_W-1:0] ivWrData,
  input  logic [BLK_W-1:0]  engOut,
  output logic [BLK_W-1:0]  engIn,
  output logic              engEncrypt,
  output logic [1:0]        engKeySize,
  output logic [BLK_W-1:0]  outBlock,
  output logic [BLK_W-1:0]  chainVal
);
  cfgT              cfgReg;
  logic [BLK_W-1:0] inReg, chainReg, outReg;
  logic [BLK_W-1:0] ctrMask, ctrNext, resultNxt, chainNxt;

  // Low counter field mask: word g belongs to the field when ctrSel >= g
  for (genvar g = 0; g < NUM_WORDS; g++) begin : gMask
    assign ctrMask[g*WORD_W +: WORD_W] = {WORD_W{cfgReg.ctrSel >= 2'(g)}};
  end

  assign ctrNext = (chainReg & ~ctrMask) | ((chainReg + 1'b1) & ctrMask);

  always_comb begin
    engEncrypt = (cfgReg.mode == MODE_CTR) ? 1'b1 : cfgReg.enc;
    engKeySize = cfgReg.keySz;
    unique case (cfgReg.mode)
      MODE_CTR: engIn = chainReg;
      MODE_CBC: engIn = cfgReg.enc ? (inReg ^ chainReg) : inReg;
      default:  engIn = inReg;
    endcase
  end

  always_comb begin
    resultNxt = engOut;
    chainNxt  = chainReg;
    unique case (cfgReg.mode)
      MODE_CTR: begin
        resultNxt = engOut ^ inReg;
        chainNxt  = ctrNext;
      end
      MODE_CBC: begin
        if (cfgReg.enc) begin
          chainNxt = engOut;
        end else begin
          resultNxt = engOut ^ chainReg;
          chainNxt  = inReg;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      inReg    <= '0;
      chainReg <= '0;
      outReg   <= '0;
    end else begin
      if (stb.takeBlock) begin
        cfgReg <= decodeCtrl(ctrlWord);
        inReg  <= inBlock;
      end
      if (stb.ivWrite) begin
        for (int k = 0; k < NUM_WORDS; k++) begin
          if (ivWrIdx == IDX_W'(k)) chainReg[k*WORD_W +: WORD_W] <= ivWrData;
        end
      end else if (stb.takeResult) begin
        chainReg <= chainNxt;
      end
      if (stb.takeResult) outReg <= resultNxt;
    end
  end

  assign outBlock = outReg;
  assign chainVal = chainReg;
endmodule

// File: rtl/blkmode_chain.sv
module blkmode_chain
  import blkmode_pkg::*;
#(
  parameter int BLK_W  = 128,
  parameter int WORD_W = 32,
  localparam int NUM_WORDS = BLK_W / WORD_W,
  localparam int IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTRL_W-1:0] ctrlWord,
  input  logic              ivWrEn,
  input  logic [IDX_W-1:0]  ivWrIdx,
  input  logic [WORD_W-1:0] ivWrData,
  input  logic              inValid,
  input  logic [BLK_W-1:0]  inBlock,
  output logic              inReady,
  output logic              outValid,
  output logic [BLK_W-1:0]  outBlock,
  output logic              busy,
  output logic              engStart,
  output logic              engEncrypt,
  output logic [1:0]        engKeySize,
  output logic [BLK_W-1:0]  engIn,
  input  logic              engDone,
  input  logic [BLK_W-1:0]  engOut
);
  strobeT           stb;
  logic [BLK_W-1:0] chainVal;

  blkmode_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .ivWrEn(ivWrEn),
    .engDone(engDone), .stb(stb), .inReady(inReady), .busy(busy),
    .engStart(engStart), .outValid(outValid)
  );

  blkmode_dp #(.BLK_W(BLK_W), .WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .ctrlWord(ctrlWord),
    .inBlock(inBlock), .ivWrIdx(ivWrIdx), .ivWrData(ivWrData),
    .engOut(engOut), .engIn(engIn), .engEncrypt(engEncrypt),
    .engKeySize(engKeySize), .outBlock(outBlock), .chainVal(chainVal)
  );
endmodule

// File: rtl/blkmode_chain_chk.sv
module blkmode_chain_chk #(
  parameter int BLK_W = 128
) (
  input logic             clk,
  input logic             rstN,
  input logic             busy,
  input logic             inReady,
  input logic             inValid,
  input logic             ivWrEn,
  input logic             engStart,
  input logic             engDone,
  input logic             outValid,
  input logic [BLK_W-1:0] chainVal
);
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    engStart |=> !engStart);                                   // R8
  AST_OUT_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);                                   // R8
  AST_ACCEPT_LAUNCH: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> engStart);                        // R8
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !inReady);                                        // R9
  AST_IV_PRIORITY: assert property (@(posedge clk) disable iff (!rstN)
    ivWrEn |-> !inReady);                                      // R7
  AST_IV_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !engDone) |=> $stable(chainVal));                 // R7
endmodule

bind blkmode_chain blkmode_chain_chk #(.BLK_W(BLK_W)) uChk (.*);

// File: tb/blkmode_chain_test.sv
module blkmode_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [127:0] KEY_BASE = 128'h3c5a_9e17_d2b4_6f80_1a2b_3c4d_5e6f_7081;

  logic         clk = 0, rstN = 0;
  logic [8:0]   ctrlWord = '0;
  logic         ivWrEn = 0;
  logic [1:0]   ivWrIdx = '0;
  logic [31:0]  ivWrData = '0;
  logic         inValid = 0;
  logic [127:0] inBlock = '0;
  logic         inReady, outValid, busy, engStart, engEncrypt;
  logic [127:0] outBlock, engIn;
  logic [1:0]   engKeySize;
  logic         engDone;
  logic [127:0] engOut;

  int nChecks = 0, nErr = 0;
  logic [127:0] mChain = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkmode_chain uut (.*);

  function automatic logic [127:0] perm(input logic [127:0] x, input logic enc, input logic [1:0] ksz);
    logic [127:0] key = KEY_BASE + 128'(ksz);
    if (enc) return {x[119:0], x[127:120]} ^ key;
    else begin
      logic [127:0] y = x ^ key;
      return {y[7:0], y[127:8]};
    end
  endfunction

  // engine stand-in with random latency
  logic         sEnc; logic [1:0] sKsz; logic [127:0] sIn;
  logic         pend; logic [1:0] lat;
  always @(posedge clk) begin
    if (!rstN) begin
      pend <= 0; engDone <= 0; engOut <= '0; sEnc <= 0; sKsz <= '0; sIn <= '0; lat <= '0;
    end else begin
      engDone <= 0;
      if (engStart) begin
        pend <= 1; sIn <= engIn; sEnc <= engEncrypt; sKsz <= engKeySize;
        lat <= 2'($urandom % 3);
      end else if (pend) begin
        if (lat == 0) begin
          engDone <= 1; engOut <= perm(sIn, sEnc, sKsz); pend <= 0;
        end else lat <= lat - 1;
      end
    end
  end

  function automatic logic [8:0] mkCtrl(input logic ctr, input logic cbc, input logic enc,
                                        input logic [1:0] ksz, input logic [1:0] sel);
    return {sel, ctr, cbc, ksz, enc, 2'b00};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // model: returns expected output and engine direction, updates mChain
  task automatic model(input logic [8:0] c, input logic [127:0] d,
                       output logic [127:0] expOut, output logic expEnc);
    logic ctr = c[6];
    logic cbc = c[5] & ~c[6];
    logic enc = c[2];
    logic [1:0] ksz = c[4:3];
    int w = 32 * (int'(c[8:7]) + 1);
    logic [127:0] m;
    if (ctr) begin
      m = (w == 128) ? {128{1'b1}} : ((128'd1 << w) - 128'd1);
      expOut = perm(mChain, 1'b1, ksz) ^ d; expEnc = 1'b1;
      mChain = (mChain & ~m) | ((mChain + 128'd1) & m);
    end else if (cbc && enc) begin
      expOut = perm(d ^ mChain, 1'b1, ksz); expEnc = 1'b1; mChain = expOut;
    end else if (cbc) begin
      expOut = perm(d, 1'b0, ksz) ^ mChain; expEnc = 1'b0; mChain = d;
    end else begin
      expOut = perm(d, enc, ksz); expEnc = enc;
    end
  endtask

  task automatic ivWrite(input logic [1:0] idx, input logic [31:0] v);
    @(negedge clk); ivWrEn = 1; ivWrIdx = idx; ivWrData = v;
    @(negedge clk); ivWrEn = 0;
    mChain[32*idx +: 32] = v;
  endtask

  task automatic loadIv(input logic [127:0] v);
    for (int k = 0; k < 4; k++) ivWrite(2'(k), v[32*k +: 32]);
  endtask

  task automatic waitOut(input string tag, output logic [127:0] res);
    int t = 0;
    while (!outValid && t < 100) begin @(negedge clk); t++; end
    if (t >= 100) begin nChecks++; nErr++; $display("FAIL %s R8: no outValid, actual 0 expected 1", tag); end
    res = outBlock;
    @(negedge clk);
    chk({tag, " R8 outValid single cycle"}, 128'(outValid), 128'd0);
  endtask

  // send one block, optionally attempting an IV write while busy; checks everything
  task automatic runBlock(input string tag, input logic [8:0] c, input logic [127:0] d,
                          input logic busyWr, output logic [127:0] res);
    logic [127:0] e; logic eEnc;
    model(c, d, e, eEnc);
    @(negedge clk); ctrlWord = c; inBlock = d; inValid = 1;
    while (!inReady) @(negedge clk);
    @(negedge clk); inValid = 0;
    if (busyWr) begin
      chk({tag, " R9 busy blocks ready"}, 128'({busy, inReady}), 128'b10);
      ivWrEn = 1; ivWrIdx = 2'd0; ivWrData = 32'hdead_beef;
      @(negedge clk); ivWrEn = 0;
    end
    waitOut(tag, res);
    chk({tag, " out"}, res, e);
    chk({tag, " R3 engEncrypt"}, 128'(sEnc), 128'(eEnc));
    chk({tag, " R4 engKeySize"}, 128'(sKsz), 128'(c[4:3]));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErr++; nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [127:0] r, ct [3], pt [3], ctrRes;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset inReady/busy/outValid/engStart", 128'({inReady, busy, outValid, engStart}), 128'b1000);

    // R1 + R6: CTR before any IV load uses counter 0
    runBlock("R1 CTR counter zero", mkCtrl(1,0,1,2'd1,2'd0), 128'h1111, 0, r);
    chk("R1 explicit zero counter", r, perm(128'd0, 1'b1, 2'd1) ^ 128'h1111);

    // R2/R3 ECB both directions
    runBlock("R2 ECB encrypt", mkCtrl(0,0,1,2'd1,2'd0), 128'h0123_4567_89ab_cdef, 0, r);
    runBlock("R2 ECB decrypt", mkCtrl(0,0,0,2'd2,2'd0), 128'hfeed_f00d, 0, r);
    chk("R2 ECB decrypt explicit", r, perm(128'hfeed_f00d, 1'b0, 2'd2));

    // R2: bits 6 and 5 set -> CTR wins; R3 decrypt direction still runs engine forward
    runBlock("R2 CTR over CBC", mkCtrl(1,1,0,2'd3,2'd3), 128'h55aa, 0, r);

    // R4 each key-size code
    for (int k = 1; k < 4; k++) runBlock("R4 key code", mkCtrl(0,0,1,2'(k),2'd0), 128'(k * 77), 0, r);

    // R5 CBC encrypt chain, then decrypt round trip
    loadIv(128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100);
    for (int i = 0; i < 3; i++) begin
      pt[i] = {$urandom, $urandom, $urandom, $urandom};
      runBlock("R5 CBC encrypt", mkCtrl(0,1,1,2'd1,2'd0), pt[i], 0, ct[i]);
    end
    loadIv(128'h0f0e_0d0c_0b0a_0908_0706_0504_0302_0100);
    for (int i = 0; i < 3; i++) begin
      runBlock("R5 CBC decrypt", mkCtrl(0,1,0,2'd1,2'd0), ct[i], 0, r);
      chk("R5 CBC round trip", r, pt[i]);
    end

    // R6 CTR wrap inside each field width, upper bits kept
    for (int s = 0; s < 4; s++) begin
      loadIv({128{1'b1}});
      runBlock("R6 CTR wrap first", mkCtrl(1,0,1,2'd1,2'(s)), 128'h0, 0, r);
      runBlock("R6 CTR wrap second", mkCtrl(1,0,0,2'd1,2'(s)), 128'h0, 0, ctrRes);
      chk("R6 wrapped counter explicit", ctrRes,
          perm(s == 3 ? 128'd0 : ({128{1'b1}} << (32 * (s + 1))), 1'b1, 2'd1));
    end

    // R7 IV write while busy is ignored
    loadIv(128'h1234_5678_9abc_def0_1357_9bdf_2468_ace0);
    runBlock("R7 busy IV write", mkCtrl(0,1,1,2'd1,2'd0), 128'haaaa, 1, r);
    runBlock("R7 chain unaffected", mkCtrl(0,1,1,2'd1,2'd0), 128'hbbbb, 0, r);

    // R7 priority: IV write and block offered in same idle cycle
    @(negedge clk); ivWrEn = 1; ivWrIdx = 2'd3; ivWrData = 32'hcafe_0001;
    ctrlWord = mkCtrl(1,0,1,2'd1,2'd0); inBlock = 128'h77; inValid = 1;
    #1 chk("R7 write blocks inReady", 128'(inReady), 128'd0);
    inValid = 0;
    @(negedge clk); ivWrEn = 0;
    mChain[96 +: 32] = 32'hcafe_0001;
    runBlock("R7 new IV used next block", mkCtrl(1,0,1,2'd1,2'd0), 128'h77, 0, r);

    // random mix of modes, IV loads and latencies
    for (int i = 0; i < 80; i++) begin
      if ($urandom % 8 == 0) ivWrite(2'($urandom % 4), $urandom);
      runBlock("R2 random block", 9'($urandom), {$urandom, $urandom, $urandom, $urandom},
               ($urandom % 5 == 0), r);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule